// File: doc/BRIEF.md
# Descriptor Ring DMA Engine

This block drives a circular ring of transfer descriptors held in host memory. Software fills descriptors and then moves the ring's tail index through a small write port. The engine owns the head index. Whenever the head trails the tail, the engine reads the descriptor under the head and passes its source, destination and byte count to a copy-request output for an external data mover. It then waits for the mover to report the result, writes a status word back into the descriptor and, if the descriptor asks for it, pulses an interrupt request. The head steps forward only after that status write is acknowledged, and it wraps from the last slot back to slot 0.

Each descriptor occupies 32 bytes, and slot i sits at `ring_base + 32*i`. The bytes are laid out as follows: bytes 0-7 hold the source address, bytes 8-15 the destination, bytes 16-19 the length, bytes 20-23 the control word and bytes 24-27 the status word. Bit 0 of the control word requests an interrupt. The descriptor read, the copy request and the status write each use valid/ready handshakes. Once valid is raised, it and its payload stay unchanged until the cycle in which ready is sampled high, and that cycle is the transfer. The read response, the mover's done report and the write acknowledge are single-cycle pulses with no back-pressure. Only one stage is active at any time.

Top module: `dring_engine`

## Requirements
- R1: After reset, `head_o` and `tail_o` are 0, `rd_req_valid`, `cp_valid` and `wb_valid` are low, and `irq_o` is low.
- R2: While `head_o` equals `tail_o`, the engine issues no descriptor read and stays idle.
- R3: A descriptor read is requested at address `ring_base + 32*head_o`. The address and `rd_req_valid` stay stable until `rd_req_ready` is seen.
- R4: The copy request carries bits [63:0] of the 256-bit read response as source, bits [127:64] as destination and bits [159:128] as length. The request holds stable while `cp_ready` is low.
- R5: The status write goes to `ring_base + 32*head_o + 24`. Its data is the done code (1) if `cp_done_err` was low with `cp_done_valid`, and the error code (2) if it was high. The write holds stable while `wb_ready` is low.
- R6: `head_o` changes only on the cycle after `wb_ack`. It then becomes `(head_o+1) mod N`, so it wraps from N-1 to 0.
- R7: `irq_o` is high for exactly the one cycle after `wb_ack`, and only when bit 160 of the descriptor (bit 0 of the control word) was 1.
- R8: A tail write with a value of N or more is ignored: `tail_o`, `head_o` and all request outputs behave as if no write had occurred.
- R9: At most one of `rd_req_valid`, `cp_valid` and `wb_valid` is high in any cycle.
- R10: An accepted tail write appears on `tail_o` on the cycle after `tail_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | 64 | Byte address of ring slot 0 |
| tail_wr | input | 1 | Software tail write strobe |
| tail_val | input | $clog2(N)+1 | New tail index |
| head_o | output | $clog2(N) | Hardware head index |
| tail_o | output | $clog2(N) | Current tail index |
| rd_req_valid | output | 1 | Descriptor read request valid |
| rd_req_ready | input | 1 | Descriptor read request accepted |
| rd_req_addr | output | 64 | Descriptor byte address |
| rd_rsp_valid | input | 1 | Descriptor data returned |
| rd_rsp_data | input | 256 | Whole descriptor |
| cp_valid | output | 1 | Copy request valid |
| cp_ready | input | 1 | Copy request accepted |
| cp_src | output | 64 | Copy source address |
| cp_dst | output | 64 | Copy destination address |
| cp_len | output | 32 | Copy length in bytes |
| cp_done_valid | input | 1 | Mover finished the copy |
| cp_done_err | input | 1 | Mover reports a fault |
| wb_valid | output | 1 | Status write valid |
| wb_ready | input | 1 | Status write accepted |
| wb_addr | output | 64 | Status word byte address |
| wb_data | output | 32 | Status code |
| wb_ack | input | 1 | Status write committed |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
The hardest situation to reach is the head wrapping past slot N-1 while software has also placed the tail behind the head in index order. Tail writes that land there are valid, and they have to be told apart from out-of-range tail writes, which must be ignored. The bench sweeps tail values through every number from 0 to 2N-1 in a stride that is coprime to 2N, so the head passes the wrap several times and every illegal value appears between legal ones. Each handshake is stalled for a varying number of cycles so that the stability rules come into play.

// File: rtl/dring_pkg.sv
package dring_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_FWAIT, S_COPY, S_CWAIT, S_WB, S_WWAIT
  } seq_state_e;

  // 32-byte descriptor image, byte 0 in the low bits
  typedef struct packed {
    logic [31:0] spare;
    logic [31:0] status;
    logic [31:0] ctrl;
    logic [31:0] len;
    logic [63:0] dst;
    logic [63:0] src;
  } desc_t;

  localparam int SLOT_SHIFT   = 5;
  localparam int STATUS_OFS   = 24;
  localparam int CTRL_IRQ_BIT = 0;
endpackage

// File: rtl/dring_ptr.sv
module dring_ptr #(
  parameter int N_ENTRIES = 4,
  localparam int IDX_W  = $clog2(N_ENTRIES),
  localparam int TAIL_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tail_wr,
  input  logic [TAIL_W-1:0] tail_val,
  input  logic              adv,
  output logic [IDX_W-1:0]  head,
  output logic [IDX_W-1:0]  tail,
  output logic              empty
);
  localparam logic [IDX_W-1:0]  LAST  = IDX_W'(N_ENTRIES - 1);
  localparam logic [TAIL_W-1:0] LIMIT = TAIL_W'(N_ENTRIES);

  logic tail_ok;
  assign tail_ok = tail_wr && (tail_val < LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else begin
      if (tail_ok) tail <= tail_val[IDX_W-1:0];
      if (adv) head <= (head == LAST) ? '0 : head + 1'b1;
    end
  end

  assign empty = (head == tail);
endmodule

// File: rtl/dring_seq.sv
module dring_seq
  import dring_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  parameter logic [31:0] DONE_CODE = 32'd1,
  parameter logic [31:0] ERR_CODE  = 32'd2,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [63:0]      ring_base,
  input  logic [IDX_W-1:0] head,
  input  logic             empty,
  output logic             adv,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [63:0]      rd_req_addr,
  input  logic             rd_rsp_valid,
  input  logic [255:0]     rd_rsp_data,
  output logic             cp_valid,
  input  logic             cp_ready,
  output logic [63:0]      cp_src,
  output logic [63:0]      cp_dst,
  output logic [31:0]      cp_len,
  input  logic             cp_done_valid,
  input  logic             cp_done_err,
  output logic             wb_valid,
  input  logic             wb_ready,
  output logic [63:0]      wb_addr,
  output logic [31:0]      wb_data,
  input  logic             wb_ack,
  output logic             irq_o
);
  seq_state_e state_q, state_d;
  desc_t      desc_q;
  logic       err_q;
  logic       irq_q;
  logic [63:0] slot_addr;

  assign slot_addr = ring_base + (64'(head) << SLOT_SHIFT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (!empty)        state_d = S_FETCH;
      S_FETCH: if (rd_req_ready)  state_d = S_FWAIT;
      S_FWAIT: if (rd_rsp_valid)  state_d = S_COPY;
      S_COPY:  if (cp_ready)      state_d = S_CWAIT;
      S_CWAIT: if (cp_done_valid) state_d = S_WB;
      S_WB:    if (wb_ready)      state_d = S_WWAIT;
      S_WWAIT: if (wb_ack)        state_d = S_IDLE;
      default:                    state_d = S_IDLE;
    endcase
  end

  assign adv = (state_q == S_WWAIT) && wb_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      desc_q  <= '0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_FWAIT && rd_rsp_valid) desc_q <= desc_t'(rd_rsp_data);
      if (state_q == S_CWAIT && cp_done_valid) err_q <= cp_done_err;
      irq_q <= adv && desc_q.ctrl[CTRL_IRQ_BIT];
    end
  end

  assign rd_req_valid = (state_q == S_FETCH);
  assign rd_req_addr  = slot_addr;
  assign cp_valid     = (state_q == S_COPY);
  assign cp_src       = desc_q.src;
  assign cp_dst       = desc_q.dst;
  assign cp_len       = desc_q.len;
  assign wb_valid     = (state_q == S_WB);
  assign wb_addr      = slot_addr + 64'(STATUS_OFS);
  assign wb_data      = err_q ? ERR_CODE : DONE_CODE;
  assign irq_o        = irq_q;
endmodule

// File: rtl/dring_engine.sv
module dring_engine #(
  parameter int N_ENTRIES = 4,
  parameter logic [31:0] DONE_CODE = 32'd1,
  parameter logic [31:0] ERR_CODE  = 32'd2,
  localparam int IDX_W  = $clog2(N_ENTRIES),
  localparam int TAIL_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       ring_base,
  input  logic              tail_wr,
  input  logic [TAIL_W-1:0] tail_val,
  output logic [IDX_W-1:0]  head_o,
  output logic [IDX_W-1:0]  tail_o,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [63:0]       rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [255:0]      rd_rsp_data,
  output logic              cp_valid,
  input  logic              cp_ready,
  output logic [63:0]       cp_src,
  output logic [63:0]       cp_dst,
  output logic [31:0]       cp_len,
  input  logic              cp_done_valid,
  input  logic              cp_done_err,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [63:0]       wb_addr,
  output logic [31:0]       wb_data,
  input  logic              wb_ack,
  output logic              irq_o
);
  logic adv, empty;

  dring_ptr #(.N_ENTRIES(N_ENTRIES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .tail_wr(tail_wr), .tail_val(tail_val),
    .adv(adv), .head(head_o), .tail(tail_o), .empty(empty)
  );

  dring_seq #(.N_ENTRIES(N_ENTRIES), .DONE_CODE(DONE_CODE), .ERR_CODE(ERR_CODE)) u_seq (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .head(head_o),
    .empty(empty), .adv(adv),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .cp_valid(cp_valid), .cp_ready(cp_ready), .cp_src(cp_src), .cp_dst(cp_dst),
    .cp_len(cp_len), .cp_done_valid(cp_done_valid), .cp_done_err(cp_done_err),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data),
    .wb_ack(wb_ack), .irq_o(irq_o)
  );
endmodule

// File: rtl/dring_chk.sv
module dring_chk #(
  parameter int N_ENTRIES = 4,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] head_o,
  input logic             rd_req_valid,
  input logic             rd_req_ready,
  input logic [63:0]      rd_req_addr,
  input logic             cp_valid,
  input logic             cp_ready,
  input logic [63:0]      cp_src,
  input logic [63:0]      cp_dst,
  input logic [31:0]      cp_len,
  input logic             wb_valid,
  input logic             wb_ready,
  input logic [63:0]      wb_addr,
  input logic [31:0]      wb_data,
  input logic             wb_ack,
  input logic             irq_o
);
  a_r3_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  a_r4_cp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cp_valid && !cp_ready |=> cp_valid && $stable(cp_src) && $stable(cp_dst) && $stable(cp_len));

  a_r5_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_data));

  a_r5_wb_offset: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_addr - rd_req_addr) == 64'd24);

  a_r6_head_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_ack |=> $stable(head_o));

  a_r7_irq_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(wb_ack));

  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req_valid, cp_valid, wb_valid}));
endmodule

bind dring_engine dring_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .head_o(head_o),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
  .cp_valid(cp_valid), .cp_ready(cp_ready), .cp_src(cp_src), .cp_dst(cp_dst), .cp_len(cp_len),
  .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data),
  .wb_ack(wb_ack), .irq_o(irq_o)
);

// File: tb/tb_dring_engine.sv
module tb_dring_engine;
  localparam int N = 4;
  localparam int IW = $clog2(N);
  localparam int TW = IW + 1;
  localparam logic [63:0] BASE = 64'h0000_0040_0001_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tail_wr = 1'b0;
  logic [TW-1:0] tail_val = '0;
  logic [IW-1:0] head_o, tail_o;
  logic rd_req_valid, rd_req_ready = 1'b0;
  logic [63:0] rd_req_addr;
  logic rd_rsp_valid = 1'b0;
  logic [255:0] rd_rsp_data = '0;
  logic cp_valid, cp_ready = 1'b0;
  logic [63:0] cp_src, cp_dst;
  logic [31:0] cp_len;
  logic cp_done_valid = 1'b0, cp_done_err = 1'b0;
  logic wb_valid, wb_ready = 1'b0;
  logic [63:0] wb_addr;
  logic [31:0] wb_data;
  logic wb_ack = 1'b0;
  logic irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int exp_head = 0;
  int exp_tail = 0;
  int k_desc  = 0;

  always #2.5 clk = ~clk;

  dring_engine #(.N_ENTRIES(N)) dut (
    .clk(clk), .rst_n(rst_n), .ring_base(BASE), .tail_wr(tail_wr), .tail_val(tail_val),
    .head_o(head_o), .tail_o(tail_o),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .cp_valid(cp_valid), .cp_ready(cp_ready), .cp_src(cp_src), .cp_dst(cp_dst), .cp_len(cp_len),
    .cp_done_valid(cp_done_valid), .cp_done_err(cp_done_err),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data),
    .wb_ack(wb_ack), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        summary();
      end
    end
  end

  task automatic idle_quiet(input int cycles, input string req);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check(!rd_req_valid && !cp_valid && !wb_valid, req, {61'd0, rd_req_valid, cp_valid, wb_valid}, 64'd0);
      check(head_o == IW'(exp_head), req, 64'(head_o), 64'(exp_head));
    end
  endtask

  task automatic write_tail(input int t);
    tail_wr = 1'b1; tail_val = TW'(t);
    @(negedge clk);
    tail_wr = 1'b0;
    if (t < N) exp_tail = t;
    check(tail_o == IW'(exp_tail), (t < N) ? "R10" : "R8", 64'(tail_o), 64'(exp_tail));
  endtask

  task automatic serve_one(input int k);
    logic [63:0] src, dst, slot;
    logic [31:0] len, ctrl;
    bit err;
    int stall, w;
    src  = 64'hA000_0000_0000_0000 + 64'(k) * 64'h1_0100;
    dst  = 64'hB000_0000_0000_0000 + 64'(k) * 64'h2_0200;
    len  = 32'(k * 8 + 16);
    ctrl = {31'd0, (k % 2) == 0};
    err  = (k % 3) == 2;
    stall = k % 3;
    slot = BASE + 64'(exp_head) * 64'd32;
    w = 0;
    while (!rd_req_valid && w < 20) begin @(negedge clk); w++; end
    check(rd_req_valid, "R3", 64'(rd_req_valid), 64'd1);
    check(rd_req_addr == slot, "R3", rd_req_addr, slot);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(rd_req_valid && rd_req_addr == slot, "R3", rd_req_addr, slot);
    end
    rd_req_ready = 1'b1; @(negedge clk); rd_req_ready = 1'b0;
    rd_rsp_valid = 1'b1;
    rd_rsp_data  = {32'd0, 32'hFFFF_FFFF, ctrl, len, dst, src};
    @(negedge clk);
    rd_rsp_valid = 1'b0; rd_rsp_data = '0;
    check(cp_valid && cp_src == src, "R4", cp_src, src);
    check(cp_dst == dst, "R4", cp_dst, dst);
    check(cp_len == len, "R4", 64'(cp_len), 64'(len));
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(cp_valid && cp_src == src && cp_dst == dst, "R4", cp_src, src);
    end
    cp_ready = 1'b1; @(negedge clk); cp_ready = 1'b0;
    check(!cp_valid && !wb_valid, "R9", {62'd0, cp_valid, wb_valid}, 64'd0);
    cp_done_valid = 1'b1; cp_done_err = err; @(negedge clk);
    cp_done_valid = 1'b0; cp_done_err = 1'b0;
    check(wb_valid && wb_addr == slot + 64'd24, "R5", wb_addr, slot + 64'd24);
    check(wb_data == (err ? 32'd2 : 32'd1), "R5", 64'(wb_data), err ? 64'd2 : 64'd1);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(wb_valid && wb_addr == slot + 64'd24, "R5", wb_addr, slot + 64'd24);
    end
    wb_ready = 1'b1; @(negedge clk); wb_ready = 1'b0;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(head_o == IW'(exp_head), "R6", 64'(head_o), 64'(exp_head));
      check(!irq_o, "R7", 64'(irq_o), 64'd0);
    end
    wb_ack = 1'b1; @(negedge clk); wb_ack = 1'b0;
    exp_head = (exp_head + 1) % N;
    check(head_o == IW'(exp_head), "R6", 64'(head_o), 64'(exp_head));
    check(irq_o == ctrl[0], "R7", 64'(irq_o), 64'(ctrl[0]));
    @(negedge clk);
    check(!irq_o, "R7", 64'(irq_o), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(head_o == '0 && tail_o == '0, "R1", {head_o, tail_o}, 64'd0);
    check(!rd_req_valid && !cp_valid && !wb_valid && !irq_o, "R1",
          {60'd0, rd_req_valid, cp_valid, wb_valid, irq_o}, 64'd0);
    idle_quiet(4, "R2");
    for (int r = 0; r < 4 * N; r++) begin
      int t;
      t = (r * 3 + 1) % (2 * N);
      write_tail(t);
      if (t >= N) begin
        idle_quiet(6, "R8");
      end else begin
        while (exp_head != exp_tail) begin
          serve_one(k_desc);
          k_desc++;
        end
        idle_quiet(3, "R2");
      end
    end
    summary();
  end
endmodule